// File: doc/BRIEF.md
# Pixel Region Hit Latency Buffer

This block holds the hits of a small region of pixels, one column of four, while the trigger decision is still on its way. Each pixel's discriminator output is sampled on the bunch-crossing clock. A rising edge on any unmasked pixel starts an event. The arrival time of the event goes into a pool of eight latency counters that the whole region shares. Each pixel keeps its own array of time-over-threshold (charge) values, with one entry for each slot of the pool.

When an event's counter reaches the programmed latency, the block samples the trigger input once. A trigger in that cycle keeps the event for readout. Without one, the slot is released in the next cycle. Kept events go to the column readout one at a time, as a 4-bit hit map and four 4-bit charge values. The presented event stays unchanged until the readout acknowledges it, and the acknowledge frees the slot.

Top module: `pix_region_buf`

## Requirements
- R1: A pixel starts or joins an event on a clock edge where its discriminator is sampled high, the previous sample was low, and its mask bit is 0. A pixel with its mask bit at 1 never appears in a hit map, and a rise made only by masked pixels creates no event.
- R2: All unmasked pixels that rise on the same edge share one event. Bit p of the hit map (bit 0 = pixel 0) is 1 exactly for those pixels.
- R3: The charge of a pixel in an event is the number of consecutive high samples starting with the rising sample, saturating at 15. It is reported in bits [4p+3:4p] of the charge output. A pixel that is not in the hit map reports 0.
- R4: With programmed latency L, the trigger input is sampled on exactly the L-th clock edge after the edge that captured the rise. If it is high there, the event is kept. If it is low there, the event is discarded and never appears at the readout, even when the trigger is high one edge earlier or one edge later.
- R5: Up to eight events are held at once. A rise that finds all eight slots occupied is dropped, and the overflow count rises by one, saturating at its maximum. The overflow count changes only in such a cycle.
- R6: Kept events are offered one at a time. `rd_valid_o` rises one cycle after an event is kept and the readout is idle. Hit map and charge stay stable until `rd_ack_i` is sampled high. After the acknowledge, valid is low for at least one cycle, and among several kept events the lowest slot index is offered next.
- R7: After reset, `rd_valid_o` is 0 and the overflow count is 0.
- R8: A slot released by a discard or an acknowledge can hold a new event from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| disc_i | input | 4 | Discriminator outputs, bit p = pixel p |
| mask_i | input | 4 | Per-pixel mask, 1 = pixel ignored for new events |
| latency_i | input | 10 | Programmed trigger latency in clock cycles |
| trigger_i | input | 1 | Trigger decision, sampled at the latency edge |
| rd_ack_i | input | 1 | Readout accepts the presented event |
| rd_valid_o | output | 1 | A kept event is presented |
| rd_hitmap_o | output | 4 | Hit map of the presented event |
| rd_tot_o | output | 16 | Charge values of the presented event, 4 bits per pixel |
| ovf_cnt_o | output | 8 | Saturating count of dropped events |

## Verification
The assertions assume that the latency input is held constant while any event is waiting, and that it is at least 16. With that latency, every charge count has frozen before its slot can be released and reused. They also assume that the acknowledge is only raised while an event is presented. The stimulus holds the latency at 20, clears the discriminators well inside that window, and raises the acknowledge for exactly one cycle, only after valid has been seen high. The sweep covers every nonzero hit pattern, with pulse widths that pass the saturation point. Trigger pulses are placed exactly on the latency edge and one edge to either side of it.

// File: rtl/prb_pkg.sv
package prb_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_HELD = 2'd2
  } slot_state_e;
endpackage

// File: rtl/prb_slot_pool.sv
module prb_slot_pool
  import prb_pkg::*;
#(
  parameter int NPIX   = 4,
  parameter int NSLOT  = 8,
  parameter int LAT_W  = 10,
  parameter int OVF_W  = 8,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIX-1:0]   rise_i,
  input  logic [LAT_W-1:0]  latency_i,
  input  logic              trigger_i,
  input  logic              rel_en_i,
  input  logic [SLOT_W-1:0] rel_slot_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic              alloc_en_o,
  output logic [SLOT_W-1:0] alloc_slot_o,
  output logic [NSLOT-1:0]  wait_o,
  output logic [NSLOT-1:0]  held_o,
  output logic [NPIX-1:0]   rd_map_o,
  output logic [OVF_W-1:0]  ovf_cnt_o
);
  slot_state_e             state_q [NSLOT];
  slot_state_e             state_d [NSLOT];
  logic [LAT_W-1:0]        cnt_q   [NSLOT];
  logic [LAT_W-1:0]        cnt_d   [NSLOT];
  logic [NPIX-1:0]         map_q   [NSLOT];
  logic [NPIX-1:0]         map_d   [NSLOT];
  logic [OVF_W-1:0]        ovf_q, ovf_d;
  logic                    has_free;
  logic [SLOT_W-1:0]       free_idx;
  logic                    any_rise;

  assign any_rise = |rise_i;

  // lowest free slot
  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (state_q[s] == SLOT_FREE) begin
        has_free = 1'b1;
        free_idx = SLOT_W'(s);
      end
    end
  end

  assign alloc_en_o   = any_rise && has_free;
  assign alloc_slot_o = free_idx;

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      state_d[s] = state_q[s];
      cnt_d[s]   = cnt_q[s];
      map_d[s]   = map_q[s];
      case (state_q[s])
        SLOT_WAIT: begin
          if (cnt_q[s] == latency_i) state_d[s] = trigger_i ? SLOT_HELD : SLOT_FREE;
          else                       cnt_d[s]   = cnt_q[s] + LAT_W'(1);
        end
        SLOT_HELD: begin
          if (rel_en_i && (rel_slot_i == SLOT_W'(s))) state_d[s] = SLOT_FREE;
        end
        default: ;
      endcase
      if (alloc_en_o && (free_idx == SLOT_W'(s))) begin
        state_d[s] = SLOT_WAIT;
        cnt_d[s]   = LAT_W'(1);
        map_d[s]   = rise_i;
      end
    end
  end

  always_comb begin
    ovf_d = ovf_q;
    if (any_rise && !has_free && (ovf_q != {OVF_W{1'b1}})) ovf_d = ovf_q + OVF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= '0;
      for (int s = 0; s < NSLOT; s++) begin
        state_q[s] <= SLOT_FREE;
        cnt_q[s]   <= '0;
        map_q[s]   <= '0;
      end
    end else begin
      ovf_q <= ovf_d;
      for (int s = 0; s < NSLOT; s++) begin
        state_q[s] <= state_d[s];
        cnt_q[s]   <= cnt_d[s];
        map_q[s]   <= map_d[s];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_slot_flags
      assign wait_o[g] = (state_q[g] == SLOT_WAIT);
      assign held_o[g] = (state_q[g] == SLOT_HELD);

      // R4
      lat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q[g] == SLOT_WAIT) |-> (cnt_q[g] <= latency_i));
    end
  endgenerate

  assign rd_map_o  = map_q[rd_slot_i];
  assign ovf_cnt_o = ovf_q;

  // R5
  ovf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_rise |=> $stable(ovf_q));
endmodule

// File: rtl/prb_pixel_tot.sv
module prb_pixel_tot #(
  parameter int NSLOT = 8,
  parameter int TOT_W = 4,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disc_i,
  input  logic              mask_i,
  input  logic              alloc_en_i,
  input  logic [SLOT_W-1:0] alloc_slot_i,
  input  logic [NSLOT-1:0]  slot_wait_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic              rise_o,
  output logic [TOT_W-1:0]  tot_o
);
  localparam logic [TOT_W-1:0] TOT_MAX = {TOT_W{1'b1}};
  localparam logic [TOT_W-1:0] TOT_ONE = TOT_W'(1);

  logic              disc_q;
  logic              open_q, open_d;
  logic [SLOT_W-1:0] pslot_q, pslot_d;
  logic [TOT_W-1:0]  tot_q [NSLOT];
  logic [TOT_W-1:0]  tot_d [NSLOT];
  logic              rise;

  assign rise   = disc_i && !disc_q && !mask_i;
  assign rise_o = rise;

  always_comb begin
    for (int s = 0; s < NSLOT; s++) tot_d[s] = tot_q[s];
    open_d  = open_q;
    pslot_d = pslot_q;
    // running measurement of the open hit
    if (open_q) begin
      if (!slot_wait_i[pslot_q] || !disc_i) begin
        open_d = 1'b0;
      end else if (tot_q[pslot_q] != TOT_MAX) begin
        tot_d[pslot_q] = tot_q[pslot_q] + TOT_ONE;
        if (tot_q[pslot_q] == TOT_MAX - TOT_ONE) open_d = 1'b0;
      end else begin
        open_d = 1'b0;
      end
    end
    // new event in the region
    if (alloc_en_i) begin
      tot_d[alloc_slot_i] = rise ? TOT_ONE : '0;
      if (rise) begin
        open_d  = 1'b1;
        pslot_d = alloc_slot_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disc_q  <= 1'b0;
      open_q  <= 1'b0;
      pslot_q <= '0;
      for (int s = 0; s < NSLOT; s++) tot_q[s] <= '0;
    end else begin
      disc_q  <= disc_i;
      open_q  <= open_d;
      pslot_q <= pslot_d;
      for (int s = 0; s < NSLOT; s++) tot_q[s] <= tot_d[s];
    end
  end

  assign tot_o = tot_q[rd_slot_i];

  // R3
  tot_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (tot_q[pslot_q] != TOT_MAX) && (tot_q[pslot_q] != '0));
endmodule

// File: rtl/prb_readout.sv
module prb_readout #(
  parameter int NSLOT = 8,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLOT-1:0]  held_i,
  input  logic              ack_i,
  output logic              valid_o,
  output logic [SLOT_W-1:0] sel_o,
  output logic              rel_en_o,
  output logic [SLOT_W-1:0] rel_slot_o
);
  logic              lock_q, lock_d;
  logic [SLOT_W-1:0] sel_q, sel_d;
  logic [SLOT_W-1:0] low_idx;

  always_comb begin
    low_idx = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (held_i[s]) low_idx = SLOT_W'(s);
    end
  end

  always_comb begin
    lock_d = lock_q;
    sel_d  = sel_q;
    if (lock_q) begin
      if (ack_i) lock_d = 1'b0;
    end else if (|held_i) begin
      lock_d = 1'b1;
      sel_d  = low_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      lock_q <= lock_d;
      sel_q  <= sel_d;
    end
  end

  assign valid_o    = lock_q;
  assign sel_o      = sel_q;
  assign rel_en_o   = lock_q && ack_i;
  assign rel_slot_o = sel_q;

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !ack_i) |=> (lock_q && $stable(sel_q)));

  // R6
  rd_sel_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> held_i[sel_q]);
endmodule

// File: rtl/pix_region_buf.sv
module pix_region_buf #(
  parameter int NPIX  = 4,
  parameter int NSLOT = 8,
  parameter int TOT_W = 4,
  parameter int LAT_W = 10,
  parameter int OVF_W = 8,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPIX-1:0]       disc_i,
  input  logic [NPIX-1:0]       mask_i,
  input  logic [LAT_W-1:0]      latency_i,
  input  logic                  trigger_i,
  input  logic                  rd_ack_i,
  output logic                  rd_valid_o,
  output logic [NPIX-1:0]       rd_hitmap_o,
  output logic [NPIX*TOT_W-1:0] rd_tot_o,
  output logic [OVF_W-1:0]      ovf_cnt_o
);
  logic [NPIX-1:0]   rise;
  logic              alloc_en;
  logic [SLOT_W-1:0] alloc_slot;
  logic [NSLOT-1:0]  slot_wait;
  logic [NSLOT-1:0]  slot_held;
  logic [SLOT_W-1:0] rd_slot;
  logic              rel_en;
  logic [SLOT_W-1:0] rel_slot;

  prb_slot_pool #(
    .NPIX (NPIX),
    .NSLOT(NSLOT),
    .LAT_W(LAT_W),
    .OVF_W(OVF_W)
  ) u_pool (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_i      (rise),
    .latency_i   (latency_i),
    .trigger_i   (trigger_i),
    .rel_en_i    (rel_en),
    .rel_slot_i  (rel_slot),
    .rd_slot_i   (rd_slot),
    .alloc_en_o  (alloc_en),
    .alloc_slot_o(alloc_slot),
    .wait_o      (slot_wait),
    .held_o      (slot_held),
    .rd_map_o    (rd_hitmap_o),
    .ovf_cnt_o   (ovf_cnt_o)
  );

  genvar p;
  generate
    for (p = 0; p < NPIX; p++) begin : g_pix
      prb_pixel_tot #(
        .NSLOT(NSLOT),
        .TOT_W(TOT_W)
      ) u_pix (
        .clk         (clk),
        .rst_n       (rst_n),
        .disc_i      (disc_i[p]),
        .mask_i      (mask_i[p]),
        .alloc_en_i  (alloc_en),
        .alloc_slot_i(alloc_slot),
        .slot_wait_i (slot_wait),
        .rd_slot_i   (rd_slot),
        .rise_o      (rise[p]),
        .tot_o       (rd_tot_o[p*TOT_W +: TOT_W])
      );
    end
  endgenerate

  prb_readout #(
    .NSLOT(NSLOT)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .held_i    (slot_held),
    .ack_i     (rd_ack_i),
    .valid_o   (rd_valid_o),
    .sel_o     (rd_slot),
    .rel_en_o  (rel_en),
    .rel_slot_o(rel_slot)
  );

  // R6
  rd_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ack_i) |=> ($stable(rd_hitmap_o) && $stable(rd_tot_o)));

  // R1
  rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && $stable(mask_i)) |=> ((rd_hitmap_o & mask_i) == '0) || !rd_valid_o
      || 1'b1 == ((rd_hitmap_o & mask_i) == '0));
endmodule

// File: tb/pix_region_buf_tb.sv
module pix_region_buf_tb;
  localparam int L = 20;

  logic        clk;
  logic        rst_n;
  logic [3:0]  disc;
  logic [3:0]  mask;
  logic [9:0]  latency;
  logic        trig;
  logic        ack;
  logic        rd_valid;
  logic [3:0]  rd_map;
  logic [15:0] rd_tot;
  logic [7:0]  ovf;

  int n_chk  = 0;
  int n_fail = 0;

  pix_region_buf u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .disc_i     (disc),
    .mask_i     (mask),
    .latency_i  (latency),
    .trigger_i  (trig),
    .rd_ack_i   (ack),
    .rd_valid_o (rd_valid),
    .rd_hitmap_o(rd_map),
    .rd_tot_o   (rd_tot),
    .ovf_cnt_o  (ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_tot(input logic [3:0] pat, input int w [4]);
    logic [15:0] r = '0;
    for (int p = 0; p < 4; p++) begin
      if (pat[p]) r[p*4 +: 4] = 4'((w[p] > 15) ? 15 : w[p]);
    end
    return r;
  endfunction

  // drive one event; trigger pulse placed at edge L+off after capture
  task automatic run_hit(input logic [3:0] pat, input int w [4], input int off, input bit ten);
    for (int i = 0; i <= L + 2; i++) begin
      @(negedge clk);
      for (int p = 0; p < 4; p++) disc[p] = pat[p] && (i < w[p]);
      trig = ten && (i == L + off);
    end
    disc = '0;
    trig = 1'b0;
  endtask

  task automatic read_check(input string tag, input logic [3:0] emap, input logic [15:0] etot);
    @(negedge clk);
    check({tag, " valid"}, 32'(rd_valid), 32'd1);
    check({tag, " map"},   32'(rd_map),   32'(emap));
    check({tag, " tot"},   32'(rd_tot),   32'(etot));
    repeat (3) @(negedge clk);
    check({tag, " R6 hold map"}, 32'(rd_map), 32'(emap));
    check({tag, " R6 hold tot"}, 32'(rd_tot), 32'(etot));
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check({tag, " R6 valid drops"}, 32'(rd_valid), 32'd0);
  endtask

  task automatic expect_none(input string tag);
    repeat (4) begin
      @(negedge clk);
      check(tag, 32'(rd_valid), 32'd0);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int w [4];
    rst_n   = 1'b0;
    disc    = '0;
    mask    = '0;
    latency = 10'(L);
    trig    = 1'b0;
    ack     = 1'b0;
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7 valid", 32'(rd_valid), 32'd0);
    check("R7 ovf",   32'(ovf),      32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R4: every nonzero hit pattern, width sweep past saturation
    for (int pat = 1; pat < 16; pat++) begin
      for (int p = 0; p < 4; p++) w[p] = ((pat * 5 + p * 7) % 18) + 1;
      run_hit(4'(pat), w, 0, 1'b1);
      read_check($sformatf("R2 R3 R4 sweep pat=%0d", pat), 4'(pat), exp_tot(4'(pat), w));
    end

    // R4 trigger one edge early / late -> discarded
    w = '{4, 4, 4, 4};
    run_hit(4'b0010, w, -1, 1'b1);
    expect_none("R4 early trigger");
    run_hit(4'b0010, w, 1, 1'b1);
    expect_none("R4 late trigger");
    run_hit(4'b1001, w, 0, 1'b0);
    expect_none("R4 no trigger");

    // R1 mask: pixel 2 masked
    mask = 4'b0100;
    w = '{2, 9, 6, 16};
    run_hit(4'b1111, w, 0, 1'b1);
    read_check("R1 mask one", 4'b1011, exp_tot(4'b1011, w));
    mask = 4'b1111;
    run_hit(4'b1111, w, 0, 1'b1);
    expect_none("R1 all masked");
    check("R1 all masked ovf", 32'(ovf), 32'd0);
    mask = 4'b0000;
    repeat (4) @(negedge clk);

    // R6 queue of three kept events, lowest slot first
    for (int i = 0; i <= L + 8; i++) begin
      @(negedge clk);
      disc[0] = (i < 3);
      disc[1] = (i >= 2) && (i < 7);
      disc[2] = (i >= 4) && (i < 6);
      disc[3] = (i >= 4) && (i < 11);
      trig    = 1'b1;
    end
    disc = '0;
    trig = 1'b0;
    read_check("R6 queue first",  4'b0001, 16'h0003);
    read_check("R6 queue second", 4'b0010, 16'h0050);
    read_check("R6 queue third",  4'b1100, 16'h7200);
    expect_none("R6 queue drained");

    // R5 R8 overflow and reuse right after release
    for (int i = 0; i <= L + 23; i++) begin
      @(negedge clk);
      disc[0] = ((i <= 18) && (i % 2 == 0)) || (i == 21);
      trig    = (i == 21 + L);
    end
    disc = '0;
    trig = 1'b0;
    check("R5 ovf after two drops", 32'(ovf), 32'd2);
    read_check("R8 reuse after release", 4'b0001, 16'h0001);
    expect_none("R5 discarded full set");
    check("R5 ovf stable", 32'(ovf), 32'd2);

    finish_run();
  end
endmodule